// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the controller side of a command-driven parallel flash device. A host hands it one operation per request: a block erase, a single word write, setting one block's lock bit, or clearing all lock bits. The block then produces every bus cycle the operation needs. It sends a two-cycle command, reads status repeatedly until the device reports ready, and decodes the error bits. If the decode finds an error, it writes a clear-status command. It always ends by putting the device back into array read mode. It reports a 3-bit result code with a one-cycle done pulse.

On the device side the bus is fully synchronous. A write cycle is one clock with the write enable high, with the address and command or data on the outputs. A read cycle is one clock with the read enable high, and the status byte on the data input is captured at the end of that clock. The status byte keeps its device bit positions because the decode depends on them: bit 7 is ready, bit 5 is erase/clear error, bit 4 is write/lock error, bit 3 is program-voltage error and bit 1 is protection error.

Top module: `flash_op_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, flWe and flRe are low. An assertion of reset during an operation abandons it with no further bus cycles.
- R2: A request (reqValid high while busy is low) is accepted at that clock edge. busy is high from the next cycle through the done cycle inclusive and low after it. reqValid while busy has no effect on the bus cycles, the result or the number of done pulses.
- R3: The first two bus cycles are writes to the request address, with the code in bits 7:0 and zeros above. reqOp 0 (erase) sends 20h then D0h. reqOp 1 (word write) sends 40h, then reqData. reqOp 2 (lock set) sends 60h then 01h. reqOp 3 (clear all locks) sends 60h then D0h.
- R4: After the command, the block issues one status read per cycle at the request address until a read returns bit 7 set. No error bit is judged on a read with bit 7 clear. Write and read enables are never high together.
- R5: If MAX_POLLS reads pass without bit 7 set, polling stops after exactly MAX_POLLS reads and the result is 5 (timeout).
- R6: Result codes follow a fixed priority. Bit 3 gives 1 (voltage). Otherwise bits 4 and 5 both set give 2 (sequence). Otherwise bit 5 for reqOp 0/3, or bit 4 for reqOp 1/2, gives 3 (operation error). Otherwise bit 1 gives 4 (protect). Otherwise the result is 0.
- R7: When the result is nonzero, one clear-status write (50h) follows the last read. When the result is 0, no clear-status write is issued.
- R8: The last write of every operation is FFh (array read). done is high for exactly one cycle, in the cycle after that write, with result valid. The whole operation is 2 + reads + (1 if error) + 1 + 1 busy cycles.
- R9: Status bits 6, 2 and 0 never change the result, and neither does the error bit that does not apply to the operation type (bit 4 for erase/clear-locks, bit 5 for write/lock-set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqOp | input | 2 | Operation: 0 erase, 1 word write, 2 lock set, 3 clear locks |
| reqAddr | input | ADDR_W | Target address (block or word) |
| reqData | input | DATA_W | Word to program for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with done |
| flAddr | output | ADDR_W | Device address |
| flDout | output | DATA_W | Command or data to the device |
| flWe | output | 1 | Device write cycle |
| flRe | output | 1 | Device status read cycle |
| flDin | input | DATA_W | Status from the device, bits 7:0 used |

## Verification
A controller state that is wrong in any way shows up at the ports within one cycle. A skipped or repeated state changes the logged write sequence or the count of status reads, and it moves the done cycle away from the computed 2 + reads + error + 2 total. A decode with the wrong priority, or one that judges bits before ready, is seen at the done pulse as a wrong result code. This is checked with status bytes that carry all error bits while not ready, and with bytes that have several error bits set at once. A poll counter that is off by one shows as one read too many or too few at the timeout boundary and at ready-on-last-read.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [1:0] {
    OP_ERASE    = 2'd0,
    OP_WRITE    = 2'd1,
    OP_LOCK_SET = 2'd2,
    OP_LOCK_CLR = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RES_OK   = 3'd0,
    RES_VOLT = 3'd1,
    RES_SEQ  = 3'd2,
    RES_OPER = 3'd3,
    RES_PROT = 3'd4,
    RES_TMO  = 3'd5
  } res_e;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_FIRST,
    BUS_SECOND,
    BUS_POLL,
    BUS_CLEAR,
    BUS_ARRAY
  } bus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic pollClr;
    logic pollInc;
    logic resLatch;
    logic resTimeout;
    bus_e busSel;
  } strobe_t;

  localparam logic [7:0] CODE_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] CODE_CONFIRM      = 8'hD0;
  localparam logic [7:0] CODE_LOCK_SETUP   = 8'h60;
  localparam logic [7:0] CODE_LOCK_SET_OK  = 8'h01;
  localparam logic [7:0] CODE_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CODE_READ_ARRAY   = 8'hFF;

  // status bit positions, decoded by this block
  localparam int ST_READY = 7;
  localparam int ST_ERASE = 5;
  localparam int ST_WRITE = 4;
  localparam int ST_VOLT  = 3;
  localparam int ST_PROT  = 1;

endpackage

// File: rtl/flseq_decode.sv
module flseq_decode
  import flseq_pkg::*;
(
  input  op_e        op,
  input  logic [7:0] status,
  output res_e       res
);

  logic eraseLike;
  logic opErr;

  assign eraseLike = (op == OP_ERASE) || (op == OP_LOCK_CLR);
  assign opErr     = eraseLike ? status[ST_ERASE] : status[ST_WRITE];

  always_comb begin
    if (status[ST_VOLT])                           res = RES_VOLT;
    else if (status[ST_WRITE] && status[ST_ERASE]) res = RES_SEQ;
    else if (opErr)                                res = RES_OPER;
    else if (status[ST_PROT])                      res = RES_PROT;
    else                                           res = RES_OK;
  end

endmodule

// File: rtl/flseq_dp.sv
module flseq_dp
  import flseq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int MAX_POLLS   = 64,
  parameter logic [7:0] WRITE_SETUP = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] flDin,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDout,
  output logic              flWe,
  output logic              flRe,
  output logic              statReady,
  output logic              statErr,
  output logic              pollLast,
  output logic [2:0]        result
);

  localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  op_e               opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [POLL_W-1:0] pollCnt;
  res_e              resQ;
  res_e              decRes;
  logic [7:0]        firstCode;
  logic [7:0]        secondCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_ERASE;
      addrQ <= '0;
      dataQ <= '0;
    end else if (stb.load) begin
      opQ   <= op_e'(reqOp);
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pollCnt <= '0;
    else if (stb.pollClr) pollCnt <= '0;
    else if (stb.pollInc) pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resQ <= RES_OK;
    else if (stb.resTimeout) resQ <= RES_TMO;
    else if (stb.resLatch)   resQ <= decRes;
  end

  flseq_decode u_dec (
    .op    (opQ),
    .status(flDin[7:0]),
    .res   (decRes)
  );

  assign statReady = flDin[ST_READY];
  assign statErr   = (decRes != RES_OK);
  assign pollLast  = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign result    = resQ;
  assign flAddr    = addrQ;

  always_comb begin
    unique case (opQ)
      OP_ERASE: firstCode = CODE_ERASE_SETUP;
      OP_WRITE: firstCode = WRITE_SETUP;
      default:  firstCode = CODE_LOCK_SETUP;
    endcase
    unique case (opQ)
      OP_LOCK_SET: secondCode = CODE_LOCK_SET_OK;
      default:     secondCode = CODE_CONFIRM;
    endcase
  end

  always_comb begin
    flWe   = 1'b0;
    flRe   = 1'b0;
    flDout = '0;
    unique case (stb.busSel)
      BUS_FIRST: begin
        flWe   = 1'b1;
        flDout = DATA_W'(firstCode);
      end
      BUS_SECOND: begin
        flWe   = 1'b1;
        flDout = (opQ == OP_WRITE) ? dataQ : DATA_W'(secondCode);
      end
      BUS_POLL: flRe = 1'b1;
      BUS_CLEAR: begin
        flWe   = 1'b1;
        flDout = DATA_W'(CODE_CLEAR_STATUS);
      end
      BUS_ARRAY: begin
        flWe   = 1'b1;
        flDout = DATA_W'(CODE_READ_ARRAY);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    statReady,
  input  logic    statErr,
  input  logic    pollLast,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);

  typedef enum logic [2:0] {
    S_IDLE, S_FIRST, S_SECOND, S_POLL, S_CLEAR, S_ARRAY, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState      = state;
    stb.load       = 1'b0;
    stb.pollClr    = 1'b0;
    stb.pollInc    = 1'b0;
    stb.resLatch   = 1'b0;
    stb.resTimeout = 1'b0;
    stb.busSel     = BUS_IDLE;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.load    = 1'b1;
          stb.pollClr = 1'b1;
          nextState   = S_FIRST;
        end
      end
      S_FIRST: begin
        stb.busSel = BUS_FIRST;
        nextState  = S_SECOND;
      end
      S_SECOND: begin
        stb.busSel = BUS_SECOND;
        nextState  = S_POLL;
      end
      S_POLL: begin
        stb.busSel = BUS_POLL;
        if (statReady) begin
          stb.resLatch = 1'b1;
          nextState    = statErr ? S_CLEAR : S_ARRAY;
        end else if (pollLast) begin
          stb.resTimeout = 1'b1;
          nextState      = S_CLEAR;
        end else begin
          stb.pollInc = 1'b1;
        end
      end
      S_CLEAR: begin
        stb.busSel = BUS_CLEAR;
        nextState  = S_ARRAY;
      end
      S_ARRAY: begin
        stb.busSel = BUS_ARRAY;
        nextState  = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flseq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 64,
  parameter logic [7:0] WRITE_SETUP = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flDout,
  output logic              flWe,
  output logic              flRe,
  input  logic [DATA_W-1:0] flDin
);

  strobe_t stb;
  logic    statReady;
  logic    statErr;
  logic    pollLast;

  flseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .statReady(statReady),
    .statErr  (statErr),
    .pollLast (pollLast),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  flseq_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_POLLS  (MAX_POLLS),
    .WRITE_SETUP(WRITE_SETUP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .flDin    (flDin),
    .flAddr   (flAddr),
    .flDout   (flDout),
    .flWe     (flWe),
    .flRe     (flRe),
    .statReady(statReady),
    .statErr  (statErr),
    .pollLast (pollLast),
    .result   (result)
  );

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic [2:0]        result,
  input logic [DATA_W-1:0] flDout,
  input logic              flWe,
  input logic              flRe
);

  localparam int RUN_W = $clog2(MAX_POLLS + 1) + 1;

  logic [RUN_W-1:0] rdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdRun <= '0;
    else if (!busy) rdRun <= '0;
    else if (flRe) rdRun <= rdRun + 1'b1;
  end

  // R4
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe));

  // R2
  bus_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flWe || flRe) |-> busy);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R8
  array_before_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(flWe) && ($past(flDout[7:0]) == 8'hFF)));

  // R5
  poll_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    flRe |-> (rdRun < RUN_W'(MAX_POLLS)));

  // R6
  result_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result <= 3'd5));

endmodule

bind flash_op_seq flash_op_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MAX_POLLS(MAX_POLLS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .flDout  (flDout),
  .flWe    (flWe),
  .flRe    (flRe)
);

// File: tb/flash_op_seq_test.sv
module flash_op_seq_test;

  localparam int ADDR_W   = 24;
  localparam int DATA_W   = 16;
  localparam int TB_POLLS = 16;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] stat;
    logic [7:0] waitPolls;
    logic [2:0] expRes;
  } vec_t;

  // op: 0 erase, 1 write, 2 lock set, 3 clear locks
  localparam vec_t VEC [15] = '{
    '{2'd0, 8'h80, 8'd0,  3'd0},  // R6 clean erase
    '{2'd0, 8'h80, 8'd5,  3'd0},  // R4 wait five polls
    '{2'd1, 8'h90, 8'd2,  3'd3},  // R6 write error
    '{2'd0, 8'h90, 8'd1,  3'd0},  // R9 bit4 ignored for erase
    '{2'd1, 8'hA0, 8'd1,  3'd0},  // R9 bit5 ignored for write
    '{2'd1, 8'hBA, 8'd0,  3'd1},  // R6 voltage wins
    '{2'd2, 8'hB2, 8'd3,  3'd2},  // R6 sequence over protect
    '{2'd0, 8'hA2, 8'd0,  3'd3},  // R6 erase error over protect
    '{2'd2, 8'h82, 8'd0,  3'd4},  // R6 protect
    '{2'd3, 8'hA0, 8'd2,  3'd3},  // R6 clear-locks error
    '{2'd2, 8'h90, 8'd0,  3'd3},  // R6 lock-set error
    '{2'd3, 8'hC5, 8'd0,  3'd0},  // R9 bits 6,2,0 ignored
    '{2'd1, 8'h82, 8'd15, 3'd4},  // R5 ready on last allowed poll
    '{2'd0, 8'hB8, 8'd16, 3'd5},  // R5 timeout
    '{2'd1, 8'h88, 8'd4,  3'd1}   // R6 voltage on write
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic              busy, done;
  logic [2:0]        result;
  logic [ADDR_W-1:0] flAddr;
  logic [DATA_W-1:0] flDout;
  logic              flWe, flRe;
  logic [DATA_W-1:0] flDin = '0;

  int total = 0;
  int bad = 0;

  // device model state
  int         mWait = 0;
  logic [7:0] mStat = 8'h80;
  int         rdCnt = 0;
  int         wrCnt = 0;
  logic [ADDR_W-1:0] wrAddr [16];
  logic [DATA_W-1:0] wrData [16];

  always #4 clk = ~clk;  // 125 MHz

  flash_op_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(TB_POLLS)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .result(result), .flAddr(flAddr), .flDout(flDout), .flWe(flWe),
    .flRe(flRe), .flDin(flDin)
  );

  // bus observer and status responder, mid-cycle
  always @(negedge clk) begin
    if (flWe && wrCnt < 16) begin
      wrAddr[wrCnt] = flAddr;
      wrData[wrCnt] = flDout;
    end
    if (flWe) wrCnt = wrCnt + 1;
    if (flRe) begin
      if (flAddr != reqAddr) begin
        total++; bad++;
        $display("FAIL R4: read addr %0h exp %0h", flAddr, reqAddr);
      end
      flDin = (rdCnt >= mWait) ? {8'h00, mStat | 8'h80} : {8'h00, mStat & 8'h7F};
      rdCnt = rdCnt + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] firstCode(input logic [1:0] op);
    case (op)
      2'd0:    return 8'h20;
      2'd1:    return 8'h40;
      default: return 8'h60;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] secondWord(input logic [1:0] op, input logic [DATA_W-1:0] d);
    case (op)
      2'd1:    return d;
      2'd2:    return 16'h0001;
      default: return 16'h00D0;
    endcase
  endfunction

  task automatic runOp(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                       input logic [DATA_W-1:0] data, input int waitPolls,
                       input logic [7:0] stat, input logic [2:0] expRes,
                       input bit poke);
    int cycles;
    int doneCnt;
    int expReads;
    int expWr;
    logic [DATA_W-1:0] expW [4];
    mWait = waitPolls; mStat = stat; rdCnt = 0; wrCnt = 0;
    flDin = '0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    cycles = 0; doneCnt = 0;
    while (cycles < 200) begin
      if (busy) cycles++;
      else begin
        check(1'b0, "R2 busy dropped early", 0, 1);
        break;
      end
      if (done) begin doneCnt++; break; end
      if (poke && cycles == 3) begin
        reqValid = 1'b1; reqOp = 2'd2; reqData = 16'h1234;
      end
      @(negedge clk);
      if (reqValid) begin
        reqValid = 1'b0; reqOp = op; reqData = data;
      end
    end
    expReads = (expRes == 3'd5) ? TB_POLLS : waitPolls + 1;
    check(result == expRes, "R6/R5/R9 result", result, expRes);
    check(rdCnt == expReads, "R4/R5 read count", rdCnt, expReads);
    check(cycles == 2 + expReads + (expRes != 0 ? 1 : 0) + 2, "R8 busy cycles",
          cycles, 2 + expReads + (expRes != 0 ? 1 : 0) + 2);
    expW[0] = {8'h00, firstCode(op)};
    expW[1] = secondWord(op, data);
    expWr = 2;
    if (expRes != 0) begin expW[expWr] = 16'h0050; expWr++; end
    expW[expWr] = 16'h00FF; expWr++;
    check(wrCnt == expWr, "R7/R8 write count", wrCnt, expWr);
    for (int k = 0; k < expWr && k < wrCnt; k++) begin
      check(wrData[k] == expW[k], (k < 2) ? "R3 command word" :
            ((k == expWr - 1) ? "R8 array read word" : "R7 clear word"),
            wrData[k], expW[k]);
      check(wrAddr[k] == addr, "R3 write address", wrAddr[k], addr);
    end
    @(negedge clk);
    check(!done && !busy, "R8 done single pulse", {done, busy}, 0);
    check(doneCnt == 1, "R8 done count", doneCnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !flWe && !flRe, "R1 in reset", {busy, done, flWe, flRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !flWe && !flRe, "R1 after reset", {busy, done, flWe, flRe}, 0);

    for (int i = 0; i < 15; i++) begin
      runOp(VEC[i].op, 24'h100000 + 24'(i) * 24'h001100, 16'hC300 | 16'(i),
            int'(VEC[i].waitPolls), VEC[i].stat, VEC[i].expRes, 1'b0);
    end

    // R2 request while busy ignored
    runOp(2'd1, 24'h0ABCDE, 16'h5A5A, 3, 8'h80, 3'd0, 1'b1);
    wrCnt = 0;
    repeat (10) @(negedge clk);
    check(!busy && wrCnt == 0, "R2 no second operation", wrCnt, 0);

    // R1 reset mid-operation
    mWait = 1000; mStat = 8'h00; rdCnt = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqAddr = 24'h000777;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(busy && flRe, "R1 polling before reset", {busy, flRe}, 3);
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !flWe && !flRe && !done, "R1 reset abandons op", {busy, flWe, flRe, done}, 0);
    rstN = 1'b1;
    wrCnt = 0;
    repeat (5) @(negedge clk);
    check(!busy && wrCnt == 0, "R1 idle after reset", wrCnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule